// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor that finishes one instruction in each clock period. In every cycle it presents the program counter to an instruction-memory read port and decodes the word that comes back. It reads two source registers from a 32-entry register file and computes with an ALU. It then either writes a result back, stores a word, or redirects the program counter. The instruction set has five register-register operations (add, sub, and, or, set-less-than), word load and store with base plus signed offset, branch-if-equal, and an absolute jump.

Instruction and data storage live outside the core as two independent ports, so a fetch and a data access never compete. Rising-edge timing sets the program counter and commits register writes. The data-memory address is latched on the falling edge, which gives the memory the second half of the cycle to answer a load, and the loaded word is committed on the next rising edge. A debug port shows the current program counter and the register write that will commit at the end of the cycle.

Top module: `mono_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0, all registers clear, and neither `dbg_wr_en` nor `dmem_we` is asserted.
- R2: R-type words (opcode 0, bits 10:6 zero) with function 0x20/0x22/0x24/0x25 write rs+rt, rs-rt, rs&rt and rs|rt into register rd (rs = bits 25:21, rt = bits 20:16, rd = bits 15:11).
- R3: Function 0x2A writes 1 into rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R4: Register 0 reads as zero, and a write aimed at it changes no state and raises no `dbg_wr_en`.
- R5: Load (opcode 0x23) forms the byte address rs + sign-extended bits 15:0. The address is latched onto `dmem_addr` at the falling edge, and `dmem_rdata` is written into rt at the next rising edge, so a following instruction can use it at once.
- R6: Store (opcode 0x2B) drives `dmem_we` with rt on `dmem_wdata` at the same address rule, and writes no register.
- R7: Branch-if-equal (opcode 0x04) sets the next PC to PC+4 + (sign-extended offset << 2) when rs equals rt, and to PC+4 otherwise. Backward offsets are allowed.
- R8: Jump (opcode 0x02) sets the next PC to {PC+4 bits 31:28, bits 25:0, 2'b00}.
- R9: Every instruction other than a branch or jump advances the PC by 4. Unknown encodings act as no-operations.
- R10: `dbg_wr_en`, `dbg_wr_addr` and `dbg_wr_data` show the register write that commits at the coming rising edge, and `dbg_pc` shows the PC of the instruction now executing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state commits on rising edge, data address on falling edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction to fetch |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address, latched on the falling edge |
| dmem_we | output | 1 | Store strobe, written at the rising edge |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |
| dbg_pc | output | 32 | PC of the executing instruction |
| dbg_wr_en | output | 1 | A register write commits at the next rising edge |
| dbg_wr_addr | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value of that write |

## Verification
A load's data return in the second half of a cycle and the commit of its result fall on the same rising edge as the PC update. That edge is also where the next instruction starts reading the just-written register. The program provokes this with a load followed at once by an add that reads the loaded register, and with a store followed by a load from the same word. Each is judged by the scoreboard's per-cycle comparison of PC and register-write values against values computed by hand from the requirements, and by the final memory contents.

// File: rtl/mono_pkg.sv
package mono_pkg;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_fn_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_is_rd;
        logic    use_imm;
        logic    mem_read;
        logic    mem_write;
        logic    is_branch;
        logic    is_jump;
        alu_fn_e alu_fn;
    } ctrl_t;
endpackage

// File: rtl/mono_decode.sv
module mono_decode
    import mono_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);
    logic [5:0] opc;
    logic [5:0] fn;
    logic       shamt_zero;

    assign opc        = instr[31:26];
    assign fn         = instr[5:0];
    assign shamt_zero = (instr[10:6] == 5'd0);

    always_comb begin
        ctrl = '0;
        ctrl.alu_fn = ALU_ADD;
        case (opc)
            OPC_RTYPE: begin
                ctrl.dst_is_rd = 1'b1;
                ctrl.reg_write = shamt_zero;
                case (fn)
                    FN_ADD:  ctrl.alu_fn = ALU_ADD;
                    FN_SUB:  ctrl.alu_fn = ALU_SUB;
                    FN_AND:  ctrl.alu_fn = ALU_AND;
                    FN_OR:   ctrl.alu_fn = ALU_OR;
                    FN_SLT:  ctrl.alu_fn = ALU_SLT;
                    default: ctrl.reg_write = 1'b0;
                endcase
            end
            OPC_LOAD: begin
                ctrl.reg_write = 1'b1;
                ctrl.use_imm   = 1'b1;
                ctrl.mem_read  = 1'b1;
            end
            OPC_STORE: begin
                ctrl.use_imm   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_fn    = ALU_SUB;
            end
            OPC_JUMP: ctrl.is_jump = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mono_alu.sv
module mono_alu
    import mono_pkg::*;
(
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  alu_fn_e         fn,
    output logic [XLEN-1:0] result,
    output logic            is_zero
);
    always_comb begin
        case (fn)
            ALU_SUB: result = op_a - op_b;
            ALU_AND: result = op_a & op_b;
            ALU_OR:  result = op_a | op_b;
            ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(op_a) < $signed(op_b))};
            default: result = op_a + op_b;
        endcase
    end
    assign is_zero = (result == '0);
endmodule

// File: rtl/mono_regfile.sv
module mono_regfile
    import mono_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int AW = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic [AW-1:0]   rd_addr_a,
    input  logic [AW-1:0]   rd_addr_b,
    output logic [XLEN-1:0] rd_data_a,
    output logic [XLEN-1:0] rd_data_b
);
    logic [XLEN-1:0] regs_d [NREGS];
    logic [XLEN-1:0] regs_q [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) regs_d[i] = regs_q[i];
        if (wr_en && (wr_addr != '0)) regs_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (rst) regs_q[i] <= '0;
            else     regs_q[i] <= regs_d[i];
        end
    end

    assign rd_data_a = (rd_addr_a == '0) ? '0 : regs_q[rd_addr_a];
    assign rd_data_b = (rd_addr_b == '0) ? '0 : regs_q[rd_addr_b];
endmodule

// File: rtl/mono_core.sv
module mono_core
    import mono_pkg::*;
#(
    parameter int NREGS = 32,
    localparam int AW = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic            dmem_we,
    output logic [XLEN-1:0] dmem_wdata,
    input  logic [XLEN-1:0] dmem_rdata,
    output logic [XLEN-1:0] dbg_pc,
    output logic            dbg_wr_en,
    output logic [AW-1:0]   dbg_wr_addr,
    output logic [XLEN-1:0] dbg_wr_data
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [XLEN-1:0] maddr_q;

    ctrl_t           ctrl;
    logic [XLEN-1:0] instr;
    logic [AW-1:0]   rs, rt, rd, wb_addr;
    logic [XLEN-1:0] imm_sext, ra, rb, alu_b, alu_y, wb_data;
    logic [XLEN-1:0] pc_plus4, br_target, jmp_target;
    logic            alu_zero, wb_en;

    assign instr    = imem_rdata;
    assign rs       = instr[21 +: AW];
    assign rt       = instr[16 +: AW];
    assign rd       = instr[11 +: AW];
    assign imm_sext = {{(XLEN-16){instr[15]}}, instr[15:0]};

    mono_decode u_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    mono_regfile #(.NREGS(NREGS)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wb_en),
        .wr_addr   (wb_addr),
        .wr_data   (wb_data),
        .rd_addr_a (rs),
        .rd_addr_b (rt),
        .rd_data_a (ra),
        .rd_data_b (rb)
    );

    assign alu_b = ctrl.use_imm ? imm_sext : rb;

    mono_alu u_alu (
        .op_a    (ra),
        .op_b    (alu_b),
        .fn      (ctrl.alu_fn),
        .result  (alu_y),
        .is_zero (alu_zero)
    );

    assign pc_plus4   = st_q.pc + XLEN'(4);
    assign br_target  = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[XLEN-1:XLEN-4], instr[25:0], 2'b00};

    assign wb_addr = ctrl.dst_is_rd ? rd : rt;
    assign wb_data = ctrl.mem_read ? dmem_rdata : alu_y;
    assign wb_en   = ctrl.reg_write && !rst && (wb_addr != '0);

    always_comb begin
        st_d = st_q;
        if (rst)                          st_d.pc = '0;
        else if (ctrl.is_jump)            st_d.pc = jmp_target;
        else if (ctrl.is_branch && alu_zero) st_d.pc = br_target;
        else                              st_d.pc = pc_plus4;
    end

    always_ff @(posedge clk) st_q <= st_d;

    always_ff @(negedge clk) maddr_q <= alu_y;

    assign imem_addr   = st_q.pc;
    assign dmem_addr   = maddr_q;
    assign dmem_we     = ctrl.mem_write && !rst;
    assign dmem_wdata  = rb;
    assign dbg_pc      = st_q.pc;
    assign dbg_wr_en   = wb_en;
    assign dbg_wr_addr = wb_addr;
    assign dbg_wr_data = wb_data;
endmodule

// File: rtl/mono_core_checker.sv
module mono_core_checker
    import mono_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_rdata,
    input logic [XLEN-1:0] dbg_pc,
    input logic            dbg_wr_en,
    input logic [4:0]      dbg_wr_addr,
    input logic            dmem_we
);
    logic [5:0]      opc;
    logic [XLEN-1:0] seq_pc, jtgt;

    assign opc    = imem_rdata[31:26];
    assign seq_pc = dbg_pc + 32'd4;
    assign jtgt   = {seq_pc[31:28], imem_rdata[25:0], 2'b00};

    a_r1_pc_reset: assert property (@(posedge clk) rst |=> dbg_pc == '0);
    a_r1_quiet_reset: assert property (@(posedge clk) rst |-> (!dbg_wr_en && !dmem_we));
    a_r4_no_zero_write: assert property (@(posedge clk) disable iff (rst)
        dbg_wr_en |-> dbg_wr_addr != 5'd0);
    a_r6_store_no_wb: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> !dbg_wr_en);
    a_r9_seq_pc: assert property (@(posedge clk) disable iff (rst)
        (opc != OPC_BEQ && opc != OPC_JUMP) |=> dbg_pc == $past(seq_pc));
    a_r8_jump_pc: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_JUMP) |=> dbg_pc == $past(jtgt));
endmodule

bind mono_core mono_core_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .imem_rdata  (imem_rdata),
    .dbg_pc      (dbg_pc),
    .dbg_wr_en   (dbg_wr_en),
    .dbg_wr_addr (dbg_wr_addr),
    .dmem_we     (dmem_we)
);

// File: tb/mono_core_test.sv
module mono_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [31:0] dbg_pc, dbg_wr_data;
    logic        dbg_wr_en;
    logic [4:0]  dbg_wr_addr;

    logic [31:0] imem [32];
    logic [31:0] dmem [16];

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mono_core uut (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_we(dmem_we),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
        .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data)
    );

    assign imem_rdata = imem[imem_addr[6:2]];
    assign dmem_rdata = dmem[dmem_addr[5:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[5:2]] <= dmem_wdata;

    typedef struct {
        logic [31:0] pc;
        logic        wen;
        logic [4:0]  waddr;
        logic [31:0] wdata;
        logic        mwe;
        string       req;
    } step_t;
    step_t sb[$];

    function automatic logic [31:0] rtype(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] itype(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic push(logic [31:0] pc, logic wen, int waddr, logic [31:0] wdata,
                        logic mwe, string req);
        step_t s;
        s.pc = pc; s.wen = wen; s.waddr = 5'(waddr); s.wdata = wdata;
        s.mwe = mwe; s.req = req;
        sb.push_back(s);
    endtask

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) imem[i] = 32'h0;
        for (int i = 0; i < 16; i++) dmem[i] = 32'h0;
        dmem[1] = 32'h0000_1234;
        dmem[4] = 32'h8000_0005;
        dmem[5] = 32'h0000_0007;
        imem[0]  = itype(6'h23, 0, 1, 16'd16);
        imem[1]  = itype(6'h23, 0, 2, 16'd20);
        imem[2]  = rtype(1, 2, 3, 6'h20);
        imem[3]  = rtype(2, 1, 4, 6'h22);
        imem[4]  = rtype(1, 2, 5, 6'h24);
        imem[5]  = rtype(1, 2, 6, 6'h25);
        imem[6]  = rtype(1, 2, 7, 6'h2A);
        imem[7]  = rtype(2, 1, 8, 6'h2A);
        imem[8]  = rtype(1, 2, 0, 6'h20);
        imem[9]  = itype(6'h2B, 5, 3, 16'd3);
        imem[10] = itype(6'h23, 0, 10, 16'd8);
        imem[11] = itype(6'h23, 5, 9, 16'hFFFF);
        imem[12] = rtype(0, 7, 11, 6'h20);
        imem[13] = itype(6'h04, 1, 2, 16'd5);
        imem[14] = itype(6'h04, 7, 11, 16'd2);
        imem[15] = rtype(1, 1, 12, 6'h20);
        imem[16] = rtype(1, 1, 12, 6'h20);
        imem[17] = {6'h02, 26'd20};
        imem[18] = rtype(1, 1, 12, 6'h20);
        imem[19] = rtype(1, 1, 12, 6'h20);
        imem[20] = itype(6'h04, 0, 0, 16'hFFFF);

        push(32'd0,  1, 1,  32'h8000_0005, 0, "R5");
        push(32'd4,  1, 2,  32'h0000_0007, 0, "R5");
        push(32'd8,  1, 3,  32'h8000_000C, 0, "R2");
        push(32'd12, 1, 4,  32'h8000_0002, 0, "R2");
        push(32'd16, 1, 5,  32'h0000_0005, 0, "R2");
        push(32'd20, 1, 6,  32'h8000_0007, 0, "R2");
        push(32'd24, 1, 7,  32'h0000_0001, 0, "R3");
        push(32'd28, 1, 8,  32'h0000_0000, 0, "R3");
        push(32'd32, 0, 0,  32'h0,         0, "R4");
        push(32'd36, 0, 0,  32'h0,         1, "R6");
        push(32'd40, 1, 10, 32'h8000_000C, 0, "R6");
        push(32'd44, 1, 9,  32'h0000_1234, 0, "R5");
        push(32'd48, 1, 11, 32'h0000_0001, 0, "R4");
        push(32'd52, 0, 0,  32'h0,         0, "R7");
        push(32'd56, 0, 0,  32'h0,         0, "R7");
        push(32'd68, 0, 0,  32'h0,         0, "R8");
        push(32'd80, 0, 0,  32'h0,         0, "R7");
        push(32'd80, 0, 0,  32'h0,         0, "R7");
        push(32'd80, 0, 0,  32'h0,         0, "R9");
    end

    // Monitor: reset state, then per-cycle scoreboard compare (sampled 3 ns after the falling edge).
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(dbg_pc == 32'd0, "R1", "pc in reset", dbg_pc, 32'd0);
        check(!dbg_wr_en && !dmem_we, "R1", "writes in reset",
              {dbg_wr_en, dmem_we}, 32'd0);
        rst = 1'b0;
        while (sb.size() > 0) begin
            step_t e;
            #3;
            e = sb.pop_front();
            check(dbg_pc == e.pc, e.req, "R10 pc", dbg_pc, e.pc);
            check(dbg_wr_en == e.wen, e.req, "R10 write enable", 32'(dbg_wr_en), 32'(e.wen));
            if (e.wen) begin
                check(dbg_wr_addr == e.waddr, e.req, "write reg", 32'(dbg_wr_addr), 32'(e.waddr));
                check(dbg_wr_data == e.wdata, e.req, "write data", dbg_wr_data, e.wdata);
            end
            check(dmem_we == e.mwe, e.req, "store strobe", 32'(dmem_we), 32'(e.mwe));
            if (e.mwe) check(dmem_addr == 32'd8, "R6", "store address", dmem_addr, 32'd8);
            @(negedge clk);
        end
        check(dmem[2] == 32'h8000_000C, "R6", "stored word", dmem[2], 32'h8000_000C);
        check(dmem[4] == 32'h8000_0005, "R6", "untouched word", dmem[4], 32'h8000_0005);
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (2000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule